// File: doc/BRIEF.md
# Programmable-Length Sync Word Detector

This block watches a serial stream of demodulated bits and reports when the most recent bits equal a configured sync word. The word is 6, 8, 12, 16, 21 or 24 bits long. It is taken from the low end of a 24-bit pattern input. The bit received first in time must equal the most significant of the active pattern bits. Correlation is exact: a single wrong bit means no match.

When the word is found, the block raises a one-cycle found pulse and sets a locked flag. While locked it stops searching. It still accepts incoming bits, and it marks the first bit after the word with a one-cycle payload-start pulse so a downstream deframer can align to it. The deframer clears the lock with a re-arm pulse. Dropping the enable clears the bit history and the lock.

The bit input is a valid/ready stream. `in_ready` is high exactly when `enable` is high and `rearm` is low. A bit is accepted only on a clock edge where both `in_valid` and `in_ready` are high. While `in_ready` is low the sender must hold its bit. There is no other back-pressure: the block never stalls an enabled, non-re-arming stream.

Top module: `sync_word_detector`

## Requirements
- R1: `len_sel` picks the match length N: code 0 gives 6, 1 gives 8, 2 gives 12, 3 gives 16, 4 gives 21, 5 gives 24, and codes 6 and 7 also give 24.
- R2: Only `sync_pattern[N-1:0]` takes part in the comparison. Bits N and above have no effect on whether a match occurs.
- R3: The earliest accepted bit of a matching word equals `sync_pattern[N-1]`, and the latest equals `sync_pattern[0]`.
- R4: When an accepted bit completes a match, `sync_found` is high for exactly the one cycle after that clock edge, and `sync_locked` rises on the same edge.
- R5: No match is reported until at least N bits have been accepted since reset, since `enable` was last low, or since the last re-arm. This holds even if the cleared history equals the pattern.
- R6: While `sync_locked` is high, bits are still accepted, no further `sync_found` occurs, and the lock holds until re-arm, disable or reset.
- R7: A `rearm` cycle clears `sync_locked` and the bit history. `in_ready` is low during it, so a bit offered in that cycle is not taken, and a new match needs N fresh bits.
- R8: While `enable` is low, `in_ready` is low, and on the following edge the history, the bit count, the lock and all pulses are cleared.
- R9: `payload_start` is high for one cycle after the edge that accepts the first bit following a match. It stays low for later bits until the block is re-armed.
- R10: `in_ready` equals `enable` and not `rearm`. Cycles with `in_valid` low change nothing.
- R11: After reset, `sync_found`, `sync_locked` and `payload_start` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Detector enable; low clears history and lock |
| in_valid | input | 1 | A received bit is offered |
| in_ready | output | 1 | The detector takes the offered bit |
| in_bit | input | 1 | Received bit value |
| sync_pattern | input | 24 | Sync word, right-justified; low N bits used |
| len_sel | input | 3 | Match length code (see R1) |
| rearm | input | 1 | One-cycle request to clear the lock and search again |
| sync_found | output | 1 | One-cycle pulse on a match |
| sync_locked | output | 1 | High from a match until re-arm or disable |
| payload_start | output | 1 | One-cycle marker for the first bit after the word |

## Verification
Two events can compete in one cycle. A re-arm can arrive together with a bit that would complete a second copy of the word or be the payload's first bit. Disabling can also fall on the same edge as a match. The bench provokes both by issuing `rearm` or dropping `enable` on exactly those bit positions. It judges the result with a bit-level reference model: the clear must win, no pulse may appear, and a fresh N-bit word must be needed afterwards. An all-zero pattern after a clear shows that the fill count, not the zeroed history, gates the first match.

// File: rtl/sync_det_pkg.sv
package sync_det_pkg;

  typedef enum logic [2:0] {
    LEN_6  = 3'd0,
    LEN_8  = 3'd1,
    LEN_12 = 3'd2,
    LEN_16 = 3'd3,
    LEN_21 = 3'd4,
    LEN_24 = 3'd5
  } sync_len_e;

  // Map a length code to a bit count; unlisted codes select the longest word.
  function automatic int unsigned sync_len_bits(input logic [2:0] code);
    case (code)
      LEN_6:   return 6;
      LEN_8:   return 8;
      LEN_12:  return 12;
      LEN_16:  return 16;
      LEN_21:  return 21;
      default: return 24;
    endcase
  endfunction

endpackage

// File: rtl/sync_len_mask.sv
module sync_len_mask
  import sync_det_pkg::*;
#(
  parameter int HIST_W = 24,
  parameter int CNT_W  = $clog2(HIST_W + 1)
) (
  input  logic [2:0]        len_sel,
  output logic [HIST_W-1:0] cmp_mask,
  output logic [CNT_W-1:0]  need_bits
);

  int unsigned len_i;

  always_comb begin
    len_i = sync_len_bits(len_sel);
    if (len_i > HIST_W) len_i = HIST_W;
    need_bits = CNT_W'(len_i);
  end

  // One enable bit per history position: active when below the word length.
  for (genvar i = 0; i < HIST_W; i++) begin : g_mask
    assign cmp_mask[i] = (len_i > i);
  end

endmodule

// File: rtl/sync_hist_shift.sv
module sync_hist_shift #(
  parameter int HIST_W = 24,
  parameter int CNT_W  = $clog2(HIST_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              shift,
  input  logic              bit_in,
  output logic [HIST_W-1:0] hist_nxt,
  output logic [CNT_W-1:0]  fill_nxt,
  output logic [CNT_W-1:0]  fill_q
);

  localparam logic [CNT_W-1:0] FILL_MAX = CNT_W'(HIST_W);

  logic [HIST_W-2:0] hist_q;

  // Newest bit enters at position 0; the oldest kept bit falls off the top.
  assign hist_nxt = {hist_q, bit_in};
  assign fill_nxt = (fill_q == FILL_MAX) ? fill_q : fill_q + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      hist_q <= '0;
      fill_q <= '0;
    end else if (shift) begin
      hist_q <= hist_nxt[HIST_W-2:0];
      fill_q <= fill_nxt;
    end
  end

  assert_clear_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (fill_q == '0));

  assert_fill_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= FILL_MAX);

endmodule

// File: rtl/sync_lock_ctrl.sv
module sync_lock_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic rearm,
  input  logic accept,
  input  logic hit,
  output logic found,
  output logic locked,
  output logic pay_start
);

  logic marked;

  always_ff @(posedge clk) begin
    if (!rst_n || !enable || rearm) begin
      found     <= 1'b0;
      locked    <= 1'b0;
      pay_start <= 1'b0;
      marked    <= 1'b0;
    end else begin
      found     <= hit;
      if (hit) locked <= 1'b1;
      pay_start <= accept && locked && !marked;
      if (accept && locked) marked <= 1'b1;
    end
  end

  assert_found_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    found |=> !found);

  assert_found_with_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> locked);

  assert_lock_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && enable && !rearm) |=> locked);

  assert_no_hit_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> !hit);

  assert_rearm_unlocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rearm |=> !locked);

  assert_payload_after_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pay_start |-> $past(locked));

  assert_payload_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pay_start |=> !pay_start);

endmodule

// File: rtl/sync_word_detector.sv
module sync_word_detector #(
  parameter int HIST_W = 24,
  parameter int LEN_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_bit,
  input  logic [HIST_W-1:0] sync_pattern,
  input  logic [LEN_W-1:0]  len_sel,
  input  logic              rearm,
  output logic              sync_found,
  output logic              sync_locked,
  output logic              payload_start
);

  localparam int CNT_W = $clog2(HIST_W + 1);

  logic [HIST_W-1:0] cmp_mask;
  logic [HIST_W-1:0] hist_nxt;
  logic [CNT_W-1:0]  need_bits;
  logic [CNT_W-1:0]  fill_nxt;
  logic [CNT_W-1:0]  fill_q;
  logic              accept;
  logic              shift;
  logic              word_eq;
  logic              hit;

  assign in_ready = enable && !rearm;
  assign accept   = in_valid && in_ready;
  assign shift    = accept && !sync_locked;

  sync_len_mask #(.HIST_W(HIST_W), .CNT_W(CNT_W)) u_mask (
    .len_sel   (len_sel),
    .cmp_mask  (cmp_mask),
    .need_bits (need_bits)
  );

  sync_hist_shift #(.HIST_W(HIST_W), .CNT_W(CNT_W)) u_hist (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (!in_ready),
    .shift    (shift),
    .bit_in   (in_bit),
    .hist_nxt (hist_nxt),
    .fill_nxt (fill_nxt),
    .fill_q   (fill_q)
  );

  // Compare against the history as it will stand once this bit is shifted in.
  assign word_eq = ((hist_nxt ^ sync_pattern) & cmp_mask) == '0;
  assign hit     = shift && word_eq && (fill_nxt >= need_bits);

  sync_lock_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .rearm     (rearm),
    .accept    (accept),
    .hit       (hit),
    .found     (sync_found),
    .locked    (sync_locked),
    .pay_start (payload_start)
  );

  assert_match_needs_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sync_found |-> (fill_q >= need_bits));

  assert_idle_keeps_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && enable && !rearm) |=> (!sync_found && $stable(sync_locked) && $stable(fill_q)));

endmodule

// File: tb/sync_word_detector_test.sv
module sync_word_detector_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_bit = 1'b0;
  logic [23:0] sync_pattern = '0;
  logic [2:0]  len_sel = '0;
  logic        rearm = 1'b0;
  logic        in_ready;
  logic        sync_found;
  logic        sync_locked;
  logic        payload_start;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  // Reference model state
  logic [23:0] m_hist = '0;
  int          m_fill = 0;
  logic        m_lock = 0;
  logic        m_mark = 0;
  logic        m_found = 0;
  logic        m_pay = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  sync_word_detector uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .in_valid(in_valid),
    .in_ready(in_ready), .in_bit(in_bit), .sync_pattern(sync_pattern),
    .len_sel(len_sel), .rearm(rearm), .sync_found(sync_found),
    .sync_locked(sync_locked), .payload_start(payload_start)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // R1: length code to bit count
  function automatic int len_of(input logic [2:0] s);
    case (s)
      3'd0: return 6;
      3'd1: return 8;
      3'd2: return 12;
      3'd3: return 16;
      3'd4: return 21;
      default: return 24;
    endcase
  endfunction

  function automatic logic rnd();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  task automatic check(input logic act, input logic exp, input string req, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s (%s): actual %0b expected %0b at cycle %0d", req, tag, act, exp, cycles);
    end
  endtask

  task automatic step(input logic v, input logic b, input logic rr, input logic en, input string tag);
    int n;
    logic [23:0] mask;
    logic acc;
    in_valid = v; in_bit = b; rearm = rr; enable = en;
    #1;
    check(in_ready, en && !rr, "R10", tag);
    n = len_of(len_sel);
    mask = (n >= 24) ? 24'hFFFFFF : 24'((1 << n) - 1);
    acc = v && en && !rr;
    if (!en || rr) begin
      m_hist = '0; m_fill = 0; m_lock = 0; m_mark = 0; m_found = 0; m_pay = 0;
    end else if (acc && m_lock) begin
      m_found = 0; m_pay = !m_mark; m_mark = 1;
    end else if (acc) begin
      m_hist = {m_hist[22:0], b};
      if (m_fill < 24) m_fill++;
      m_found = (m_fill >= n) && (((m_hist ^ sync_pattern) & mask) == 24'h0);
      if (m_found) m_lock = 1;
      m_pay = 0;
    end else begin
      m_found = 0; m_pay = 0;
    end
    @(posedge clk);
    @(negedge clk);
    check(sync_found, m_found, "R4", tag);
    check(sync_locked, m_lock, "R6", tag);
    check(payload_start, m_pay, "R9", tag);
  endtask

  // R3: send the active word earliest-bit first, from pattern bit N-1 down to 0
  task automatic send_word(input string tag);
    for (int i = len_of(len_sel) - 1; i >= 0; i--) step(1, sync_pattern[i], 0, 1, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: reset state
    check(sync_found, 0, "R11", "reset found");
    check(sync_locked, 0, "R11", "reset locked");
    check(payload_start, 0, "R11", "reset payload");

    // R1 R2 R3: every length code, several patterns with random upper bits
    for (int s = 0; s < 8; s++) begin
      len_sel = 3'(s);
      for (int p = 0; p < 3; p++) begin
        for (int k = 0; k < 24; k++) sync_pattern[k] = rnd();
        for (int k = 0; k < 20; k++) step(rnd(), rnd(), 0, 1, "R2 noise");
        send_word("R3 word");
        for (int k = 0; k < 6; k++) step(k != 2, rnd(), 0, 1, "R9 payload");
        step(1, rnd(), 1, 1, "R7 rearm");
        send_word("R1 second word");
        step(1, rnd(), 1, 1, "R7 rearm");
      end
    end

    // R5: all-zero pattern needs N accepted bits after a clear
    sync_pattern = 24'h000000;
    len_sel = 3'd0;
    step(1, 0, 1, 1, "R5 clear");
    for (int k = 0; k < 5; k++) step(1, 0, 0, 1, "R5 short fill");
    step(1, 0, 0, 1, "R5 full fill");
    step(1, 1, 1, 1, "R7 rearm");

    // R7: rearm coincides with the bit that would complete the word
    sync_pattern = 24'hABC5A5;
    len_sel = 3'd1;
    for (int i = 7; i >= 1; i--) step(1, sync_pattern[i], 0, 1, "R7 partial");
    step(1, sync_pattern[0], 1, 1, "R7 rearm on last bit");
    send_word("R7 fresh word");
    step(1, 1, 1, 1, "R7 rearm on payload bit");
    step(1, 0, 0, 1, "R7 after rearm");

    // R8: disable mid-word and on the completing bit
    for (int i = 7; i >= 3; i--) step(1, sync_pattern[i], 0, 1, "R8 partial");
    step(1, 0, 0, 0, "R8 disabled");
    for (int i = 2; i >= 0; i--) step(1, sync_pattern[i], 0, 1, "R8 tail only");
    step(1, 0, 1, 1, "R8 clear");
    for (int i = 7; i >= 1; i--) step(1, sync_pattern[i], 0, 1, "R8 partial2");
    step(1, sync_pattern[0], 0, 0, "R8 disable on last bit");
    send_word("R8 word after enable");
    step(0, 0, 0, 0, "R8 disable while locked");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule